// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block decides, at each instruction boundary, whether the core should take an interrupt. It has two request groups. Software requests carry biased levels 1 to 15. External request lines use their summary bit position as their level, from 16 to 31. The block folds both groups into one resolved level and one summary mask, then compares the level against the current priority level. When the request wins, it loads a summary register and an interrupt-ID register and raises a one-cycle trap request.

A pending-check flag gates the evaluation. `chk_set` sets the flag, and every evaluation clears it. No evaluation happens when the program counter is in privileged mode or when the controller is resuming after an instruction-fetch miss. An asynchronous-trap request that is nonzero while an evaluation runs is unsupported. In that case the block raises an error pulse and takes no interrupt.

Top module: `irq_level_arbiter`

## Requirements
- R1: Software request bit j (0..14) stands for level j+1. Among the software bits, the highest set bit gives the software level.
- R2: External request bit j (0..15) stands for level 16+j. Among the external bits, the highest set bit gives the external level.
- R3: Any set external bit overrides the software level. When no request is set at all, the resolved level is 0.
- R4: The summary mask has a 1 at position j+1 for each set software bit j and at position 16+j for each set external bit j. All other positions are 0.
- R5: An interrupt is taken only when an evaluation runs, the resolved level is nonzero and it is strictly greater than `cur_ipl`.
- R6: On the clock edge that takes an interrupt, `isr_out` loads the summary mask, `int_id` loads the level and `trap_req` goes high for exactly that following cycle. At all other times `isr_out` and `int_id` hold their values.
- R7: An evaluation runs only in a cycle where `insn_boundary` is 1, the pending flag is set, `priv_mode` is 0 and `fetch_miss_done` is 0.
- R8: `chk_pending` is set by `chk_set` and cleared by an evaluation. If `chk_set` arrives in the same cycle as an evaluation, the flag stays set.
- R9: An evaluation with nonzero `async_req` pulses `async_err` for one cycle. It takes no interrupt and leaves `isr_out` and `int_id` unchanged.
- R10: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_set | input | 1 | Sets the pending-check flag |
| insn_boundary | input | 1 | Instruction boundary strobe |
| sw_req | input | 15 | Software request bits, bit j = level j+1 |
| ext_req | input | 16 | External request lines, bit j = level 16+j |
| cur_ipl | input | 5 | Current priority level |
| priv_mode | input | 1 | Program counter in privileged mode |
| fetch_miss_done | input | 1 | Resuming after a fetch miss |
| async_req | input | 4 | Asynchronous-trap request register |
| chk_pending | output | 1 | Pending-check flag |
| trap_req | output | 1 | One-cycle interrupt trap request |
| isr_out | output | 32 | Interrupt summary register |
| int_id | output | 5 | Interrupt ID register |
| async_err | output | 1 | Unsupported asynchronous-trap error pulse |

## Verification
The tests use several request patterns:
- Single software bits and pairs of software bits check the bias and the choice of the highest bit.
- Mixed software and external sets show that the external group overrides the software group while the summary still keeps both.
- Levels equal to `cur_ipl` and one above it separate the strict comparison from a non-strict one.
- Boundaries with the gates closed (privileged mode, fetch-miss resume, flag clear) separate the gating from the compare.
- A pending set that coincides with an evaluation shows which of the two wins.
- A long pseudo-random stretch, compared every cycle against a behavioural model, mixes all of these cases.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int REQ_W  = 32;
    localparam int LVL_W  = 5;
    localparam int SW_CNT = 15;
    localparam int EXT_CNT = 16;
    localparam int AST_W  = 4;

    typedef struct packed {
        logic              pending;
        logic              trap;
        logic              err;
        logic [REQ_W-1:0]  isr;
        logic [LVL_W-1:0]  id;
    } arb_state_t;
endpackage

// File: rtl/irq_range_scan.sv
module irq_range_scan #(
    parameter int CNT   = 15,
    parameter int POS   = 1,
    parameter int LVL0  = 1,
    parameter int REQ_W = 32,
    parameter int LVL_W = 5
) (
    input  logic [CNT-1:0]   req,
    output logic             hit,
    output logic [LVL_W-1:0] level,
    output logic [REQ_W-1:0] mask
);
    // place each request at its summary position
    always_comb begin
        mask = '0;
        for (int j = 0; j < CNT; j++) begin
            mask[POS+j] = req[j];
        end
    end

    // the last set bit in ascending order is the highest one
    always_comb begin
        hit   = 1'b0;
        level = '0;
        for (int j = 0; j < CNT; j++) begin
            if (req[j]) begin
                hit   = 1'b1;
                level = LVL_W'(LVL0 + j);
            end
        end
    end

    always_comb begin
        assert (!hit || (int'(level) >= LVL0 && int'(level) < LVL0 + CNT))
            else $error("assert_level_in_range_R1_R2");
    end
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
    parameter int REQ_W = 32,
    parameter int LVL_W = 5
) (
    input  logic             sw_hit,
    input  logic [LVL_W-1:0] sw_lvl,
    input  logic [REQ_W-1:0] sw_mask,
    input  logic             ext_hit,
    input  logic [LVL_W-1:0] ext_lvl,
    input  logic [REQ_W-1:0] ext_mask,
    input  logic [LVL_W-1:0] cur_ipl,
    output logic [LVL_W-1:0] level,
    output logic [REQ_W-1:0] summary,
    output logic             wins
);
    always_comb begin
        if (ext_hit)     level = ext_lvl;
        else if (sw_hit) level = sw_lvl;
        else             level = '0;
        summary = sw_mask | ext_mask;
        wins    = (level != '0) && (level > cur_ipl);
    end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int SW_POS  = 1,
    parameter int EXT_POS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_set,
    input  logic               insn_boundary,
    input  logic [SW_CNT-1:0]  sw_req,
    input  logic [EXT_CNT-1:0] ext_req,
    input  logic [LVL_W-1:0]   cur_ipl,
    input  logic               priv_mode,
    input  logic               fetch_miss_done,
    input  logic [AST_W-1:0]   async_req,
    output logic               chk_pending,
    output logic               trap_req,
    output logic [REQ_W-1:0]   isr_out,
    output logic [LVL_W-1:0]   int_id,
    output logic               async_err
);
    localparam int SW_LVL0 = 1;

    logic             sw_hit, ext_hit, wins;
    logic [LVL_W-1:0] sw_lvl, ext_lvl, level;
    logic [REQ_W-1:0] sw_mask, ext_mask, summary;
    logic             eval_now, take;
    arb_state_t       st_d, st_q;

    irq_range_scan #(.CNT(SW_CNT), .POS(SW_POS), .LVL0(SW_LVL0),
                     .REQ_W(REQ_W), .LVL_W(LVL_W)) u_sw_scan (
        .req(sw_req), .hit(sw_hit), .level(sw_lvl), .mask(sw_mask));

    irq_range_scan #(.CNT(EXT_CNT), .POS(EXT_POS), .LVL0(EXT_POS),
                     .REQ_W(REQ_W), .LVL_W(LVL_W)) u_ext_scan (
        .req(ext_req), .hit(ext_hit), .level(ext_lvl), .mask(ext_mask));

    irq_resolve #(.REQ_W(REQ_W), .LVL_W(LVL_W)) u_resolve (
        .sw_hit(sw_hit), .sw_lvl(sw_lvl), .sw_mask(sw_mask),
        .ext_hit(ext_hit), .ext_lvl(ext_lvl), .ext_mask(ext_mask),
        .cur_ipl(cur_ipl), .level(level), .summary(summary), .wins(wins));

    always_comb begin
        eval_now = insn_boundary && st_q.pending && !priv_mode && !fetch_miss_done;
        take     = eval_now && (async_req == '0) && wins;
        st_d         = st_q;
        st_d.pending = chk_set || (st_q.pending && !eval_now);
        st_d.trap    = take;
        st_d.err     = eval_now && (async_req != '0);
        if (take) begin
            st_d.isr = summary;
            st_d.id  = level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chk_pending = st_q.pending;
    assign trap_req    = st_q.trap;
    assign isr_out     = st_q.isr;
    assign int_id      = st_q.id;
    assign async_err   = st_q.err;

    assert_taken_above_ipl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (int_id != '0) && (int_id > $past(cur_ipl)));
    assert_hold_regs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> ($stable(isr_out) && $stable(int_id)));
    assert_priv_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_mode || fetch_miss_done || !chk_pending) |=> !trap_req && !async_err);
    assert_pending_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !$past(chk_set)) |-> !chk_pending);
    assert_async_no_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        async_err |-> !trap_req);
endmodule

// File: tb/tb_irq_level_arbiter.sv
module tb_irq_level_arbiter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_set = 0, insn_boundary = 0, priv_mode = 0, fetch_miss_done = 0;
    logic [14:0] sw_req = '0;
    logic [15:0] ext_req = '0;
    logic [4:0]  cur_ipl = '0;
    logic [3:0]  async_req = '0;
    logic        chk_pending, trap_req, async_err;
    logic [31:0] isr_out;
    logic [4:0]  int_id;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural model state
    bit          m_pend, m_trap, m_err;
    logic [31:0] m_isr;
    logic [4:0]  m_id;

    irq_level_arbiter dut (
        .clk(clk), .rst_n(rst_n), .chk_set(chk_set), .insn_boundary(insn_boundary),
        .sw_req(sw_req), .ext_req(ext_req), .cur_ipl(cur_ipl), .priv_mode(priv_mode),
        .fetch_miss_done(fetch_miss_done), .async_req(async_req),
        .chk_pending(chk_pending), .trap_req(trap_req), .isr_out(isr_out),
        .int_id(int_id), .async_err(async_err));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R8", "chk_pending", chk_pending, m_pend);
        check("R5", "trap_req", trap_req, m_trap);
        check("R4", "isr_out", isr_out, m_isr);
        check("R1/R2/R3", "int_id", int_id, m_id);
        check("R9", "async_err", async_err, m_err);
    endtask

    // next model state from current inputs, applied at the edge
    task automatic model_step();
        int lvl = 0;
        logic [31:0] sm = '0;
        bit ev, tk;
        for (int j = 0; j < 15; j++) if (sw_req[j]) begin lvl = j + 1; sm[j+1] = 1'b1; end
        for (int j = 0; j < 16; j++) if (ext_req[j]) begin lvl = 16 + j; sm[16+j] = 1'b1; end
        ev = insn_boundary && m_pend && !priv_mode && !fetch_miss_done;
        tk = ev && (async_req == 0) && (lvl != 0) && (lvl > int'(cur_ipl));
        m_pend = chk_set || (m_pend && !ev);
        m_trap = tk;
        m_err  = ev && (async_req != 0);
        if (tk) begin m_isr = sm; m_id = 5'(lvl); end
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        chk_set = 0; insn_boundary = 0; priv_mode = 0; fetch_miss_done = 0;
        async_req = 0;
    endtask

    // arm the flag, then evaluate with the given requests
    task automatic take_try(logic [14:0] s, logic [15:0] e, logic [4:0] ipl);
        idle(); chk_set = 1; cyc();
        chk_set = 0; sw_req = s; ext_req = e; cur_ipl = ipl; insn_boundary = 1; cyc();
        idle(); cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_pend = 0; m_trap = 0; m_err = 0; m_isr = '0; m_id = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        compare_all();
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // R1: single software bit j=4 -> level 5; then pair -> highest
        take_try(15'h0010, 16'h0, 5'd0);
        check("R1", "sw level 5", int_id, 5);
        take_try(15'h0104, 16'h0, 5'd0);
        check("R1", "sw pair level 9", int_id, 9);
        // R2/R3: external overrides software, summary keeps both
        take_try(15'h2000, 16'h0010, 5'd0);
        check("R3", "ext override level 20", int_id, 20);
        check("R4", "summary mixed", isr_out, 32'h0010_4000);
        take_try(15'h0, 16'h8002, 5'd3);
        check("R2", "ext level 31", int_id, 31);
        // R5: equal level not taken, one above taken
        take_try(15'h0040, 16'h0, 5'd7);
        check("R5", "equal level held id", int_id, 31);
        take_try(15'h0040, 16'h0, 5'd6);
        check("R5", "above level id", int_id, 7);
        // R3/R5: no requests -> level 0, not taken
        take_try(15'h0, 16'h0, 5'd0);
        check("R3", "empty level held", int_id, 7);
        // R7: privileged mode, fetch miss resume, and no pending
        idle(); chk_set = 1; cyc();
        chk_set = 0; sw_req = 15'h7fff; ext_req = '0; cur_ipl = 0;
        insn_boundary = 1; priv_mode = 1; cyc();
        check("R7", "priv no trap", trap_req, 0);
        priv_mode = 0; fetch_miss_done = 1; cyc();
        check("R7", "miss no trap", trap_req, 0);
        check("R8", "still pending", chk_pending, 1);
        fetch_miss_done = 0; cyc();
        check("R6", "trap pulse", trap_req, 1);
        check("R6", "id 15", int_id, 15);
        idle(); cyc();
        check("R6", "pulse ends", trap_req, 0);
        insn_boundary = 1; cyc();
        check("R7", "no pending no trap", trap_req, 0);
        // R8: set coincides with evaluation
        idle(); chk_set = 1; cyc();
        insn_boundary = 1; cyc();
        check("R8", "set wins", chk_pending, 1);
        // R9: asynchronous request during evaluation
        idle(); chk_set = 1; cyc();
        chk_set = 0; ext_req = 16'h0001; insn_boundary = 1; async_req = 4'h2; cyc();
        check("R9", "async err", async_err, 1);
        check("R9", "async no trap", trap_req, 0);
        idle(); ext_req = '0; cyc();

        // mixed pseudo-random stretch
        for (int k = 0; k < 3000; k++) begin
            chk_set         = ($urandom_range(0, 3) == 0);
            insn_boundary   = ($urandom_range(0, 1) == 0);
            priv_mode       = ($urandom_range(0, 7) == 0);
            fetch_miss_done = ($urandom_range(0, 7) == 0);
            async_req       = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(1, 15)) : 4'h0;
            sw_req          = ($urandom_range(0, 1) == 0) ? 15'($urandom) : 15'h0;
            ext_req         = ($urandom_range(0, 2) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
            cur_ipl         = 5'($urandom_range(0, 31));
            cyc();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule